// File: doc/BRIEF.md
# Asynchronous Serial Controller with Mode/Command Write Sequencing

This block is a byte-wide serial port for a small processor bus. The bus side has an active-low chip select, active-low read and write strobes, and one register-select line. With select low, the bus reaches the data register. With select high, writes go to the control register and reads return the status byte. A write or read takes effect once, on the first clock cycle in which its strobe and chip select are both active.

Software configures the block in a fixed order. The first control write is a mode word, which sets the baud-clock factor, the character length and the number of stop bits. Commands follow. A mode with a zero factor code requests synchronous operation; the block does not support it, and only absorbs the two sync-character writes that follow such a mode. A command with its reset bit set puts the sequencer back to expecting a mode word. Software can therefore always use the recovery string 00h, 00h, 00h, 40h.

The serial side has a transmit holding register that feeds a frame shifter, and an oversampling receiver. Both run from a baud-clock tick equal to the system clock divided by `CLK_DIV`. Each one counts the factor number of ticks per bit. Ready indications appear in the status byte and also on dedicated pins.

Top module: `sctl_top`

## Requirements
- R1: After hardware reset the status byte reads 00h, `rts_n` and `dtr_n` are high, `txd` idles high, and the sequencer expects a mode word.
- R2: The first control write after any reset is a mode word. If its bits 1:0 are 00, the next two control writes are discarded as sync characters and leave the command outputs unchanged. Later control writes are commands.
- R3: A command with bit 6 set clears the command state, the transmit holding register and the receive flags, and makes the next control write a mode word. The writes 00h, 00h, 00h, 40h reach that state from any sequencer state.
- R4: Mode bits 1:0 select the bit time: 01 is 1, 10 is 16 and 11 is 64 baud-clock ticks. Bits 3:2 give 5+code data bits. Bits 7:6 give one stop bit for 01 and two for 10 or 11. A transmitted frame is one low start bit, the data bits LSB first, then high stop bits. The line is high when idle.
- R5: Command bit 0 enables the transmitter, bit 1 drives `dtr_n` low, bit 2 enables the receiver, bit 4 requests error reset, and bit 5 drives `rts_n` low.
- R6: Status bit 0 and pin `txrdy` are high only when the transmitter is enabled and the holding register is empty. A data write fills the holding register.
- R7: A data read returns the last received byte with the bits above the character length as zero, and it clears the receive-ready flag. A data read with nothing received leaves the flag clear.
- R8: Status bit 1 and pin `rxrdy` go high when the receiver completes a character.
- R9: Status bit 4 (overrun) sets when a character completes while receive-ready is still set; the new byte replaces the old one. Status bit 5 (framing) sets when the stop bit is sampled low. An error-reset command clears both flags.
- R10: A frame starts only while the transmitter is enabled and `cts_n` is low. Otherwise the byte waits in the holding register.
- R11: The receiver re-checks the start bit half a bit time after it first sees the line low. A low pulse shorter than that is ignored and does not produce a character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 1 | 0 selects data, 1 selects control/status |
| din | input | 8 | Write data |
| dout | output | 8 | Read data; 00h when no read is active |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| txrdy | output | 1 | Transmit holding register free |
| rxrdy | output | 1 | Received character waiting |

## Verification
The bench checks that the two control writes after a sync-mode word are swallowed. A sequencer that skipped them would treat 37h as a command and drive `rts_n` low. It sends two characters without reading the first one: a design that fails to overwrite would return the stale byte, and one without overrun detection would leave bit 4 clear. It also sends a short low glitch, which a receiver without the mid-bit recheck would turn into a false character. A scoreboard decodes every transmitted frame at 5 and 8 bits, with one and two stop bits, at x16 and x64. It also holds a byte while `cts_n` is high, which catches a transmitter that starts without clear-to-send.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   typedef enum logic [1:0] {
      WS_MODE  = 2'd0,
      WS_SYNC1 = 2'd1,
      WS_SYNC2 = 2'd2,
      WS_CMD   = 2'd3
   } wseq_e;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rxst_e;

   // fields of the mode word that the serial engines use
   typedef struct packed {
      logic [1:0] stops;   // bits 7:6
      logic [1:0] len;     // bits 3:2
      logic [1:0] factor;  // bits 1:0
   } mode_t;

   // command fields that are held as state
   typedef struct packed {
      logic rts;
      logic rx_en;
      logic dtr;
      logic tx_en;
   } cmd_t;

   localparam int FAC_W = 7;

   function automatic logic [FAC_W-1:0] ticks_per_bit(input logic [1:0] code);
      case (code)
         2'b01:   ticks_per_bit = 7'd1;
         2'b10:   ticks_per_bit = 7'd16;
         2'b11:   ticks_per_bit = 7'd64;
         default: ticks_per_bit = 7'd0;
      endcase
   endfunction

endpackage

// File: rtl/sctl_wrseq.sv
module sctl_wrseq
   import sctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctl,
   input  logic [7:0] wdata,
   output mode_t      mode_o,
   output cmd_t       cmd_o,
   output logic       err_clr_o,
   output logic       soft_rst_o
);

   wseq_e st_q;
   mode_t mode_q;
   cmd_t  cmd_q;
   logic  in_cmd_wr;

   assign in_cmd_wr  = wr_ctl && (st_q == WS_CMD);
   assign soft_rst_o = in_cmd_wr && wdata[6];
   assign err_clr_o  = in_cmd_wr && wdata[4] && !wdata[6];
   assign mode_o     = mode_q;
   assign cmd_o      = cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_MODE;
         mode_q <= '0;
         cmd_q  <= '0;
      end else if (wr_ctl) begin
         case (st_q)
            WS_MODE: begin
               mode_q <= '{stops: wdata[7:6], len: wdata[3:2], factor: wdata[1:0]};
               st_q   <= (wdata[1:0] == 2'b00) ? WS_SYNC1 : WS_CMD;
            end
            WS_SYNC1: st_q <= WS_SYNC2;
            WS_SYNC2: st_q <= WS_CMD;
            default: begin
               if (wdata[6]) begin
                  st_q  <= WS_MODE;
                  cmd_q <= '0;
               end else begin
                  cmd_q <= '{rts: wdata[5], rx_en: wdata[2], dtr: wdata[1], tx_en: wdata[0]};
               end
            end
         endcase
      end
   end

   // R2: commands change only from the command state
   a_r2_cmd_stable_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != WS_CMD) |=> $stable(cmd_q));

   // R3: internal reset returns to mode-expected with commands cleared
   a_r3_ireset_to_mode: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> (st_q == WS_MODE && cmd_q == '0));

endmodule

// File: rtl/sctl_baudgen.sv
module sctl_baudgen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (CLK_DIV <= 1) begin : g_direct
         assign tick = rst_n;
      end else begin : g_count
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/sctl_tx.sv
module sctl_tx
   import sctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       tick,
   input  mode_t      mode,
   input  logic       tx_en,
   input  logic       cts_n,
   input  logic       load,
   input  logic [7:0] ldata,
   output logic       hold_free,
   output logic       txd
);

   localparam int FRAME_W = 11;

   logic [FAC_W-1:0]   fac;
   logic               active;
   logic [3:0]         nbits;
   logic [FRAME_W-1:0] frame;
   logic [7:0]         hold_q;
   logic               full_q;
   logic               busy_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [3:0]         left_q;
   logic [5:0]         tcnt_q;
   logic               go;

   assign fac    = ticks_per_bit(mode.factor);
   assign active = (fac != '0);
   assign nbits  = 4'd5 + {2'b00, mode.len};
   assign go     = tick && active && !busy_q && full_q && tx_en && !cts_n;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (4'(i) < nbits) frame[i+1] = hold_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         full_q  <= 1'b0;
         busy_q  <= 1'b0;
         shreg_q <= '1;
         left_q  <= '0;
         tcnt_q  <= '0;
      end else if (soft_rst) begin
         full_q  <= 1'b0;
         busy_q  <= 1'b0;
         shreg_q <= '1;
         left_q  <= '0;
         tcnt_q  <= '0;
      end else begin
         if (go) begin
            busy_q  <= 1'b1;
            shreg_q <= frame;
            left_q  <= nbits + (mode.stops[1] ? 4'd2 : 4'd1);
            tcnt_q  <= 6'(fac - 7'd1);
            full_q  <= 1'b0;
         end else if (tick && active && busy_q) begin
            if (tcnt_q == '0) begin
               tcnt_q <= 6'(fac - 7'd1);
               if (left_q == '0) begin
                  busy_q <= 1'b0;
               end else begin
                  shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                  left_q  <= left_q - 1'b1;
               end
            end else begin
               tcnt_q <= tcnt_q - 1'b1;
            end
         end
         if (load) begin
            hold_q <= ldata;
            full_q <= 1'b1;
         end
      end
   end

   assign hold_free = !full_q;
   assign txd       = busy_q ? shreg_q[0] : 1'b1;

   // R10: a start bit follows only a cycle with clear-to-send and enable
   a_r10_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txd) |-> $past(!cts_n && tx_en));

   // R6: a loaded byte occupies the holding register
   a_r6_load_fills_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !soft_rst) |=> !hold_free);

endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
   import sctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       tick,
   input  mode_t      mode,
   input  logic       rx_en,
   input  logic       rxd_s,
   input  logic       rd_data,
   input  logic       err_clr,
   output logic       rdy,
   output logic [7:0] data,
   output logic       overrun,
   output logic       framing
);

   logic [FAC_W-1:0] fac;
   logic             act;
   logic [2:0]       last_idx;
   rxst_e            st_q;
   logic [5:0]       cnt_q;
   logic [2:0]       bidx_q;
   logic [7:0]       shreg_q;
   logic [7:0]       data_q;
   logic             rdy_q, oe_q, fe_q;
   logic             done;

   assign fac      = ticks_per_bit(mode.factor);
   assign act      = tick && (fac != '0) && rx_en;
   assign last_idx = 3'd4 + {1'b0, mode.len};
   assign done     = act && (st_q == RX_STOP) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         bidx_q  <= '0;
         shreg_q <= '0;
         data_q  <= '0;
         rdy_q   <= 1'b0;
         oe_q    <= 1'b0;
         fe_q    <= 1'b0;
      end else if (soft_rst) begin
         st_q  <= RX_IDLE;
         cnt_q <= '0;
         rdy_q <= 1'b0;
         oe_q  <= 1'b0;
         fe_q  <= 1'b0;
      end else begin
         if (rd_data) rdy_q <= 1'b0;
         if (err_clr) begin
            oe_q <= 1'b0;
            fe_q <= 1'b0;
         end
         if (!rx_en) begin
            st_q <= RX_IDLE;
         end else if (act) begin
            case (st_q)
               RX_IDLE: begin
                  if (!rxd_s) begin
                     shreg_q <= '0;
                     bidx_q  <= '0;
                     if (fac == 7'd1) begin
                        st_q  <= RX_DATA;
                        cnt_q <= '0;
                     end else begin
                        st_q  <= RX_START;
                        cnt_q <= 6'((fac >> 1) - 7'd1);
                     end
                  end
               end
               RX_START: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else if (!rxd_s) begin
                     st_q  <= RX_DATA;
                     cnt_q <= 6'(fac - 7'd1);
                  end else begin
                     st_q <= RX_IDLE;
                  end
               end
               RX_DATA: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else begin
                     shreg_q[bidx_q] <= rxd_s;
                     cnt_q           <= 6'(fac - 7'd1);
                     if (bidx_q == last_idx) st_q <= RX_STOP;
                     else                    bidx_q <= bidx_q + 1'b1;
                  end
               end
               default: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else begin
                     st_q   <= RX_IDLE;
                     data_q <= shreg_q;
                     rdy_q  <= 1'b1;
                     if (rdy_q && !rd_data) oe_q <= 1'b1;
                     if (!rxd_s)            fe_q <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign rdy     = rdy_q;
   assign data    = data_q;
   assign overrun = oe_q;
   assign framing = fe_q;

   // R8: a completed character raises ready
   a_r8_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !soft_rst) |=> rdy);

   // R9: completing over an unread character flags overrun
   a_r9_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdy && !rd_data && !soft_rst) |=> overrun);

endmodule

// File: rtl/sctl_top.sv
module sctl_top
   import sctl_pkg::*;
#(
   parameter int CLK_DIV = 2,
   parameter int RX_SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic       reg_sel,
   input  logic [7:0] din,
   output logic [7:0] dout,
   output logic       txd,
   input  logic       rxd,
   input  logic       cts_n,
   output logic       rts_n,
   output logic       dtr_n,
   output logic       txrdy,
   output logic       rxrdy
);

   logic       wr_act, rd_act, wr_act_q, rd_act_q;
   logic       wr_fire, rd_fire;
   logic       tick, rxd_s;
   mode_t      mode;
   cmd_t       cmd;
   logic       err_clr, soft_rst;
   logic       hold_free;
   logic       rx_rdy, rx_oe, rx_fe;
   logic [7:0] rx_data;
   logic [7:0] status;

   assign wr_act  = !cs_n && !wr_n;
   assign rd_act  = !cs_n && !rd_n;
   assign wr_fire = wr_act && !wr_act_q;
   assign rd_fire = rd_act && !rd_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
      end
   end

   generate
      if (RX_SYNC == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [RX_SYNC-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[RX_SYNC-2:0], rxd};
         end
         assign rxd_s = chain_q[RX_SYNC-1];
      end
   endgenerate

   sctl_baudgen #(.CLK_DIV(CLK_DIV)) i_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   sctl_wrseq i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (wr_fire && reg_sel),
      .wdata     (din),
      .mode_o    (mode),
      .cmd_o     (cmd),
      .err_clr_o (err_clr),
      .soft_rst_o(soft_rst)
   );

   sctl_tx i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .tick     (tick),
      .mode     (mode),
      .tx_en    (cmd.tx_en),
      .cts_n    (cts_n),
      .load     (wr_fire && !reg_sel),
      .ldata    (din),
      .hold_free(hold_free),
      .txd      (txd)
   );

   sctl_rx i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .tick    (tick),
      .mode    (mode),
      .rx_en   (cmd.rx_en),
      .rxd_s   (rxd_s),
      .rd_data (rd_fire && !reg_sel),
      .err_clr (err_clr),
      .rdy     (rx_rdy),
      .data    (rx_data),
      .overrun (rx_oe),
      .framing (rx_fe)
   );

   assign txrdy  = cmd.tx_en && hold_free;
   assign rxrdy  = rx_rdy;
   assign rts_n  = !cmd.rts;
   assign dtr_n  = !cmd.dtr;
   assign status = {2'b00, rx_fe, rx_oe, 2'b00, rx_rdy, txrdy};

   always_comb begin
      if (!rd_act)      dout = 8'h00;
      else if (reg_sel) dout = status;
      else              dout = rx_data;
   end

endmodule

// File: tb/test_sctl_top.sv
module test_sctl_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, rd_n, wr_n, reg_sel;
   logic [7:0] din;
   logic [7:0] dout;
   logic       txd, rxd, cts_n, rts_n, dtr_n, txrdy, rxrdy;

   int n_chk  = 0;
   int n_fail = 0;
   logic finished = 1'b0;

   logic [7:0] exp_q[$];
   int mon_len   = 8;
   int mon_bit   = 32;
   int mon_stops = 1;
   int mon_frames = 0;

   always #5 clk = ~clk;

   sctl_top #(.CLK_DIV(2), .RX_SYNC(2)) i_sctl_top (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .reg_sel(reg_sel), .din(din), .dout(dout), .txd(txd), .rxd(rxd),
      .cts_n(cts_n), .rts_n(rts_n), .dtr_n(dtr_n), .txrdy(txrdy), .rxrdy(rxrdy)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; reg_sel = sel; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_rd(input logic sel, output logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; reg_sel = sel;
      #1 d = dout;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard driver side: queue the expected frame, then write the byte
   task automatic tx_byte(input logic [7:0] d, input logic [7:0] expect_val);
      exp_q.push_back(expect_val);
      bus_wr(1'b0, d);
   endtask

   task automatic rx_send(input logic [7:0] d, input int nbits, input logic stopv, input int bclk);
      @(negedge clk);
      rxd = 1'b0; idle(bclk);
      for (int b = 0; b < nbits; b++) begin
         rxd = d[b]; idle(bclk);
      end
      rxd = stopv; idle(bclk);
      rxd = 1'b1; idle(bclk);
   endtask

   task automatic init_seq(input logic [7:0] m);
      bus_wr(1'b1, 8'h00); bus_wr(1'b1, 8'h00); bus_wr(1'b1, 8'h00);
      bus_wr(1'b1, 8'h40); bus_wr(1'b1, m); bus_wr(1'b1, 8'h37);
   endtask

   // scoreboard monitor: decode each frame on txd and compare in order
   initial begin
      logic [7:0] got;
      logic       ok;
      logic [7:0] e;
      wait (rst_n === 1'b1);
      forever begin
         @(negedge txd);
         repeat (mon_bit / 2) @(negedge clk);
         ok  = (txd == 1'b0);
         got = 8'h00;
         for (int b = 0; b < mon_len; b++) begin
            repeat (mon_bit) @(negedge clk);
            got[b] = txd;
         end
         for (int s = 0; s < mon_stops; s++) begin
            repeat (mon_bit) @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
         end
         mon_frames++;
         if (exp_q.size() == 0) begin
            chk("R4 unexpected frame", got, 8'hxx);
         end else begin
            e = exp_q.pop_front();
            chk("R4 frame data", got, e);
            chk("R4 start/stop levels", {7'b0, ok}, 8'h01);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; reg_sel = 1'b0; din = 8'h00;
      rxd = 1'b1; cts_n = 1'b1; rst_n = 1'b0;
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      bus_rd(1'b1, r); chk("R1 status after reset", r, 8'h00);
      chk("R1 pins rts_n,dtr_n,txd", {5'b0, rts_n, dtr_n, txd}, 8'h07);

      // R3 recovery from reset, R5 command bits
      init_seq(8'h4E);
      bus_rd(1'b0, r);
      bus_rd(1'b1, r); chk("R6 txrdy after init", r, 8'h01);
      chk("R5 rts_n,dtr_n low", {6'b0, rts_n, dtr_n}, 8'h00);
      chk("R7 data read leaves rxrdy clear", {7'b0, rxrdy}, 8'h00);

      // R3 internal reset from command state
      bus_wr(1'b1, 8'h40);
      bus_rd(1'b1, r); chk("R3 status after internal reset", r, 8'h00);
      chk("R3 rts_n high", {7'b0, rts_n}, 8'h01);

      // R2 sync-mode writes are swallowed
      bus_wr(1'b1, 8'h00); bus_wr(1'b1, 8'h37); bus_wr(1'b1, 8'h37);
      chk("R2 sync chars not commands", {6'b0, rts_n, dtr_n}, 8'h03);
      bus_wr(1'b1, 8'h00); // now a command
      // R3 recovery from SYNC1
      bus_wr(1'b1, 8'h40); bus_wr(1'b1, 8'h00);
      init_seq(8'h4E);
      bus_rd(1'b1, r); chk("R3 recovered from sync state", r, 8'h01);

      // R10 clear-to-send gating, R6 txrdy
      mon_len = 8; mon_bit = 32; mon_stops = 1;
      tx_byte(8'h55, 8'h55);
      chk("R6 txrdy low while holding", {7'b0, txrdy}, 8'h00);
      idle(400);
      chk("R10 no frame while cts_n high", 8'(mon_frames), 8'd0);
      cts_n = 1'b0;
      idle(400);
      chk("R10 frame after cts_n low", 8'(mon_frames), 8'd1);
      bus_rd(1'b1, r); chk("R6 txrdy back after start", r & 8'h01, 8'h01);
      tx_byte(8'hA3, 8'hA3);
      idle(400);

      // R4 two stop bits
      bus_wr(1'b1, 8'h40); bus_wr(1'b1, 8'hCE); bus_wr(1'b1, 8'h37);
      mon_stops = 2;
      tx_byte(8'h96, 8'h96);
      tx_byte(8'h3B, 8'h3B);
      idle(900);

      // R7, R8 receive path
      rx_send(8'h3C, 8, 1'b1, 32);
      bus_rd(1'b1, r); chk("R8 rxrdy status", r & 8'h02, 8'h02);
      chk("R8 rxrdy pin", {7'b0, rxrdy}, 8'h01);
      bus_rd(1'b0, r); chk("R7 data", r, 8'h3C);
      bus_rd(1'b1, r); chk("R7 rxrdy cleared by read", r & 8'h02, 8'h00);

      // R9 overrun
      rx_send(8'h11, 8, 1'b1, 32);
      rx_send(8'h22, 8, 1'b1, 32);
      bus_rd(1'b1, r); chk("R9 overrun flag", r & 8'h32, 8'h12);
      bus_rd(1'b0, r); chk("R9 newest byte kept", r, 8'h22);
      bus_wr(1'b1, 8'h37);
      bus_rd(1'b1, r); chk("R9 error reset clears overrun", r & 8'h30, 8'h00);

      // R9 framing
      rx_send(8'h5A, 8, 1'b0, 32);
      bus_rd(1'b1, r); chk("R9 framing flag", r & 8'h20, 8'h20);
      bus_rd(1'b0, r); chk("R9 framed byte", r, 8'h5A);
      bus_wr(1'b1, 8'h37);
      bus_rd(1'b1, r); chk("R9 error reset clears framing", r & 8'h30, 8'h00);

      // R11 glitch rejection
      @(negedge clk); rxd = 1'b0; idle(6); rxd = 1'b1;
      idle(400);
      bus_rd(1'b1, r); chk("R11 glitch gives no char", r & 8'h02, 8'h00);
      rx_send(8'h81, 8, 1'b1, 32);
      bus_rd(1'b0, r); chk("R11 receiver intact after glitch", r, 8'h81);

      // R4 5-bit x64, R7 zero fill
      bus_wr(1'b1, 8'h40); bus_wr(1'b1, 8'h43); bus_wr(1'b1, 8'h37);
      mon_len = 5; mon_bit = 128; mon_stops = 1;
      tx_byte(8'hFF, 8'h1F);
      idle(1100);
      rx_send(8'hF5, 5, 1'b1, 128);
      bus_rd(1'b0, r); chk("R7 5-bit zero fill", r, 8'h15);

      idle(200);
      chk("R4 all frames seen", 8'(exp_q.size()), 8'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule